// File: doc/BRIEF.md
# Addressed Packet Store

This block holds whole packets in a slotted on-chip memory and hands back a slot handle for each packet it keeps. Packets arrive one word per cycle on a streaming input. A keep flag is sampled on the first word. When the flag is set and a slot is free, the packet is written into that slot. One cycle after the last word, an event reports the slot handle. When no slot can take the packet, it is dropped and the event reports a failure instead.

Logic placed after the block keeps the handles wherever it likes. It later issues commands that name a handle. A read streams the stored packet back out and leaves it in place, so the packet can be read again. A free returns the slot to the pool. A read-and-free streams the packet and then releases its slot. Retrieval order is therefore set entirely by the commands, not by arrival order.

Top module: `pktvault`

## Requirements
- R1: A packet whose keep flag (`in_keep`, sampled on its first word) is low is neither stored nor reported: no event follows it and no slot is taken.
- R2: A kept packet that fits is written into the lowest-numbered free slot. The cycle after its last word, `evt_valid` is high for one cycle with `evt_fail` low and `evt_addr` set to that slot.
- R3: A successful store never reports a slot that currently holds a live packet, and storing never alters other live packets.
- R4: When every slot is occupied, a kept packet is discarded. Its event has `evt_fail` high and `evt_addr` zero.
- R5: A read command (`cmd_op` = 2'b01) on a live slot streams exactly the stored words, in order. The first word appears on `out_valid` in the second cycle after the command is accepted, and `out_last` is high only on the final word.
- R6: A read leaves the packet stored, so the same slot can be read again with identical data.
- R7: A free command (`cmd_op` = 2'b10) on a live slot releases it. Later commands on that slot are rejected, and the slot is available to the next store.
- R8: A read-and-free command (`cmd_op` = 2'b11) streams the packet as in R5 and then releases the slot.
- R9: A kept packet longer than `SLOT_WORDS` words is dropped and reported with `evt_fail` high, and its slot is returned to the free pool. A packet of exactly `SLOT_WORDS` words is stored.
- R10: A command that reads or frees a slot that is not live has no effect and raises `cmd_err` for one cycle, the cycle after acceptance. Op 2'b00 is a no-op with no error.
- R11: After reset all slots are free, `evt_valid`, `out_valid` and `cmd_err` are low and `cmd_ready` is high. `cmd_ready` is low while a read stream is still issuing words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_data | input | DATA_W | Input word |
| in_last | input | 1 | Final word of the input packet |
| in_keep | input | 1 | Store request, sampled on the first word |
| evt_valid | output | 1 | Store outcome event |
| evt_addr | output | log2(NUM_SLOTS) | Slot handle of the stored packet |
| evt_fail | output | 1 | Packet was not stored |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 none, 01 read, 10 free, 11 read and free |
| cmd_addr | input | log2(NUM_SLOTS) | Slot handle named by the command |
| cmd_ready | output | 1 | Command can be accepted this cycle |
| cmd_err | output | 1 | Previous command named a slot that is not live |
| out_valid | output | 1 | Output word present |
| out_data | output | DATA_W | Output word |
| out_last | output | 1 | Final word of the output packet |

## Verification
The hardest state to reach is a completely full slot pool combined with a slot released by an oversize drop. In that state the pool must give back the very slot it granted a moment earlier. The stimulus fills every slot with short packets and checks the refused packet. It then frees one middle slot and sends a packet one word longer than a slot. A short packet follows, and it must land in that same middle slot. Reads of the neighbouring slots then show that nothing else was overwritten.

// File: rtl/pktvault_pkg.sv
package pktvault_pkg;

    typedef enum logic [1:0] {
        OP_NONE      = 2'b00,
        OP_READ      = 2'b01,
        OP_FREE      = 2'b10,
        OP_READ_FREE = 2'b11
    } cmd_op_e;

    typedef enum logic {
        RD_IDLE   = 1'b0,
        RD_STREAM = 1'b1
    } rd_state_e;

    function automatic logic op_reads(cmd_op_e op);
        return op == OP_READ || op == OP_READ_FREE;
    endfunction

    function automatic logic op_frees(cmd_op_e op);
        return op == OP_FREE || op == OP_READ_FREE;
    endfunction

endpackage

// File: rtl/pv_slot_table.sv
module pv_slot_table #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_AW   = $clog2(NUM_SLOTS),
    parameter int LEN_W     = 7
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        alloc_en,
    output logic [SLOT_AW-1:0]          grant_slot,
    output logic                        has_free,
    input  logic                        commit_en,
    input  logic [SLOT_AW-1:0]          commit_slot,
    input  logic [LEN_W-1:0]            commit_len,
    input  logic [1:0]                  rel_en,
    input  logic [1:0][SLOT_AW-1:0]     rel_slot,
    input  logic [SLOT_AW-1:0]          look_slot,
    output logic                        look_live,
    output logic [LEN_W-1:0]            look_len,
    output logic [NUM_SLOTS-1:0]        live_vec
);
    logic [NUM_SLOTS-1:0] used_q;
    logic [NUM_SLOTS-1:0] live_q;
    logic [LEN_W-1:0]     len_q [NUM_SLOTS];

    // lowest-numbered free slot wins
    always_comb begin
        grant_slot = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!used_q[i]) grant_slot = SLOT_AW'(i);
        end
    end

    assign has_free  = ~&used_q;
    assign look_live = live_q[look_slot];
    assign look_len  = len_q[look_slot];
    assign live_vec  = live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            used_q <= '0;
            live_q <= '0;
        end else begin
            if (alloc_en) used_q[grant_slot] <= 1'b1;
            if (commit_en) live_q[commit_slot] <= 1'b1;
            for (int k = 0; k < 2; k++) begin
                if (rel_en[k]) begin
                    used_q[rel_slot[k]] <= 1'b0;
                    live_q[rel_slot[k]] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (commit_en) len_q[commit_slot] <= commit_len;
    end

endmodule

// File: rtl/pv_ingress.sv
module pv_ingress #(
    parameter int DATA_W     = 32,
    parameter int SLOT_WORDS = 64,
    parameter int SLOT_AW    = 4,
    parameter int WORD_AW    = $clog2(SLOT_WORDS),
    parameter int LEN_W      = WORD_AW + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_last,
    input  logic                        in_keep,
    input  logic                        has_free,
    input  logic [SLOT_AW-1:0]          grant_slot,
    output logic                        alloc_en,
    output logic                        commit_en,
    output logic [SLOT_AW-1:0]          commit_slot,
    output logic [LEN_W-1:0]            commit_len,
    output logic                        rel_en,
    output logic [SLOT_AW-1:0]          rel_slot,
    output logic                        mem_we,
    output logic [SLOT_AW+WORD_AW-1:0]  mem_waddr,
    output logic [DATA_W-1:0]           mem_wdata,
    output logic                        evt_valid,
    output logic [SLOT_AW-1:0]          evt_addr,
    output logic                        evt_fail
);
    logic               mid_q;
    logic               track_q;
    logic               write_q;
    logic [SLOT_AW-1:0] slot_q;
    logic [LEN_W-1:0]   idx_q;

    logic               first;
    logic               cur_track;
    logic               cur_write;
    logic [SLOT_AW-1:0] cur_slot;
    logic [LEN_W-1:0]   cur_idx;
    logic               overflow;

    assign first     = !mid_q;
    assign cur_track = first ? in_keep : track_q;
    assign cur_write = first ? (in_keep && has_free) : write_q;
    assign cur_slot  = first ? grant_slot : slot_q;
    assign cur_idx   = first ? '0 : idx_q;
    assign overflow  = cur_write && (cur_idx == LEN_W'(SLOT_WORDS));

    assign alloc_en    = in_valid && first && in_keep && has_free;
    assign mem_we      = in_valid && cur_write && !overflow;
    assign mem_waddr   = {cur_slot, cur_idx[WORD_AW-1:0]};
    assign mem_wdata   = in_data;
    assign commit_en   = mem_we && in_last;
    assign commit_slot = cur_slot;
    assign commit_len  = cur_idx + LEN_W'(1);
    assign rel_en      = in_valid && overflow;
    assign rel_slot    = cur_slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            mid_q     <= 1'b0;
            track_q   <= 1'b0;
            write_q   <= 1'b0;
            slot_q    <= '0;
            idx_q     <= '0;
            evt_valid <= 1'b0;
            evt_addr  <= '0;
            evt_fail  <= 1'b0;
        end else begin
            evt_valid <= in_valid && in_last && cur_track;
            evt_addr  <= mem_we ? cur_slot : '0;
            evt_fail  <= !mem_we;
            if (in_valid) begin
                mid_q   <= !in_last;
                track_q <= cur_track;
                write_q <= cur_write && !overflow;
                slot_q  <= cur_slot;
                if (cur_write) idx_q <= cur_idx + LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/pv_egress.sv
module pv_egress
    import pktvault_pkg::*;
#(
    parameter int SLOT_AW = 4,
    parameter int WORD_AW = 6,
    parameter int LEN_W   = WORD_AW + 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_valid,
    input  logic [1:0]                  cmd_op,
    input  logic [SLOT_AW-1:0]          cmd_addr,
    output logic                        cmd_ready,
    output logic                        cmd_err,
    input  logic                        look_live,
    input  logic [LEN_W-1:0]            look_len,
    output logic [SLOT_AW+WORD_AW-1:0]  mem_raddr,
    output logic                        out_valid,
    output logic                        out_last,
    output logic                        rel_en,
    output logic [SLOT_AW-1:0]          rel_slot
);
    rd_state_e          state_q;
    logic [SLOT_AW-1:0] slot_q;
    logic [LEN_W-1:0]   idx_q;
    logic [LEN_W-1:0]   len_q;
    logic               free_q;

    cmd_op_e op;
    logic    accept;
    logic    good;
    logic    final_word;

    assign op         = cmd_op_e'(cmd_op);
    assign cmd_ready  = state_q == RD_IDLE;
    assign accept     = cmd_valid && cmd_ready && op != OP_NONE;
    assign good       = accept && look_live;
    assign final_word = state_q == RD_STREAM && idx_q == len_q - LEN_W'(1);
    assign mem_raddr  = {slot_q, idx_q[WORD_AW-1:0]};

    always_comb begin
        rel_en   = 1'b0;
        rel_slot = cmd_addr;
        if (good && !op_reads(op) && op_frees(op)) begin
            rel_en = 1'b1;
        end else if (final_word && free_q) begin
            rel_en   = 1'b1;
            rel_slot = slot_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RD_IDLE;
            slot_q    <= '0;
            idx_q     <= '0;
            len_q     <= '0;
            free_q    <= 1'b0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            cmd_err   <= 1'b0;
        end else begin
            cmd_err   <= accept && !look_live;
            out_valid <= state_q == RD_STREAM;
            out_last  <= final_word;
            if (state_q == RD_IDLE) begin
                if (good && op_reads(op)) begin
                    state_q <= RD_STREAM;
                    slot_q  <= cmd_addr;
                    idx_q   <= '0;
                    len_q   <= look_len;
                    free_q  <= op_frees(op);
                end
            end else begin
                idx_q <= idx_q + LEN_W'(1);
                if (final_word) state_q <= RD_IDLE;
            end
        end
    end

endmodule

// File: rtl/pktvault.sv
module pktvault
    import pktvault_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int NUM_SLOTS  = 16,
    parameter int SLOT_WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          in_valid,
    input  logic [DATA_W-1:0]             in_data,
    input  logic                          in_last,
    input  logic                          in_keep,
    output logic                          evt_valid,
    output logic [$clog2(NUM_SLOTS)-1:0]  evt_addr,
    output logic                          evt_fail,
    input  logic                          cmd_valid,
    input  logic [1:0]                    cmd_op,
    input  logic [$clog2(NUM_SLOTS)-1:0]  cmd_addr,
    output logic                          cmd_ready,
    output logic                          cmd_err,
    output logic                          out_valid,
    output logic [DATA_W-1:0]             out_data,
    output logic                          out_last
);
    localparam int SLOT_AW = $clog2(NUM_SLOTS);
    localparam int WORD_AW = $clog2(SLOT_WORDS);
    localparam int LEN_W   = WORD_AW + 1;
    localparam int MEM_AW  = SLOT_AW + WORD_AW;
    localparam int DEPTH   = NUM_SLOTS * SLOT_WORDS;

    logic                        alloc_en;
    logic [SLOT_AW-1:0]          grant_slot;
    logic                        has_free;
    logic                        commit_en;
    logic [SLOT_AW-1:0]          commit_slot;
    logic [LEN_W-1:0]            commit_len;
    logic                        ig_rel_en;
    logic [SLOT_AW-1:0]          ig_rel_slot;
    logic                        eg_rel_en;
    logic [SLOT_AW-1:0]          eg_rel_slot;
    logic                        look_live;
    logic [LEN_W-1:0]            look_len;
    logic [NUM_SLOTS-1:0]        live_vec;
    logic                        mem_we;
    logic [MEM_AW-1:0]           mem_waddr;
    logic [MEM_AW-1:0]           mem_raddr;
    logic [DATA_W-1:0]           mem_wdata;
    logic [DATA_W-1:0]           mem [DEPTH];
    logic [DATA_W-1:0]           rd_data_q;

    pv_slot_table #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_AW   (SLOT_AW),
        .LEN_W     (LEN_W)
    ) table_i (
        .clk         (clk),
        .rst         (rst),
        .alloc_en    (alloc_en),
        .grant_slot  (grant_slot),
        .has_free    (has_free),
        .commit_en   (commit_en),
        .commit_slot (commit_slot),
        .commit_len  (commit_len),
        .rel_en      ({eg_rel_en, ig_rel_en}),
        .rel_slot    ({eg_rel_slot, ig_rel_slot}),
        .look_slot   (cmd_addr),
        .look_live   (look_live),
        .look_len    (look_len),
        .live_vec    (live_vec)
    );

    pv_ingress #(
        .DATA_W     (DATA_W),
        .SLOT_WORDS (SLOT_WORDS),
        .SLOT_AW    (SLOT_AW),
        .WORD_AW    (WORD_AW),
        .LEN_W      (LEN_W)
    ) ingress_i (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_last     (in_last),
        .in_keep     (in_keep),
        .has_free    (has_free),
        .grant_slot  (grant_slot),
        .alloc_en    (alloc_en),
        .commit_en   (commit_en),
        .commit_slot (commit_slot),
        .commit_len  (commit_len),
        .rel_en      (ig_rel_en),
        .rel_slot    (ig_rel_slot),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata),
        .evt_valid   (evt_valid),
        .evt_addr    (evt_addr),
        .evt_fail    (evt_fail)
    );

    pv_egress #(
        .SLOT_AW (SLOT_AW),
        .WORD_AW (WORD_AW),
        .LEN_W   (LEN_W)
    ) egress_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_ready (cmd_ready),
        .cmd_err   (cmd_err),
        .look_live (look_live),
        .look_len  (look_len),
        .mem_raddr (mem_raddr),
        .out_valid (out_valid),
        .out_last  (out_last),
        .rel_en    (eg_rel_en),
        .rel_slot  (eg_rel_slot)
    );

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_waddr] <= mem_wdata;
        rd_data_q <= mem[mem_raddr];
    end

    assign out_data = rd_data_q;

endmodule

// File: rtl/pktvault_checker.sv
module pktvault_checker #(
    parameter int NUM_SLOTS = 16,
    parameter int SLOT_AW   = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic                 in_last,
    input logic                 evt_valid,
    input logic [SLOT_AW-1:0]   evt_addr,
    input logic                 evt_fail,
    input logic                 cmd_valid,
    input logic                 cmd_ready,
    input logic                 cmd_err,
    input logic                 out_valid,
    input logic                 out_last,
    input logic [NUM_SLOTS-1:0] live_vec
);
    logic [NUM_SLOTS-1:0] live_prev;

    always_ff @(posedge clk) begin
        if (rst) live_prev <= '0;
        else     live_prev <= live_vec;
    end

    // R2: an event only ever follows the final input word
    a_r2_evt_after_last: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> $past(in_valid && in_last));

    // R3: a successful store names a slot that was not live before it
    a_r3_fresh_slot: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !evt_fail) |-> !live_prev[evt_addr]);

    // R4: a refused packet reports handle zero
    a_r4_fail_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_fail) |-> evt_addr == '0);

    // R5: last marks a word that is present
    a_r5_last_with_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R11: no command accepted while a stream still has words to issue
    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> !cmd_ready);

    // R10: an error flag answers an accepted command
    a_r10_err_follows_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(cmd_valid && cmd_ready));

endmodule

bind pktvault pktvault_checker #(
    .NUM_SLOTS (NUM_SLOTS)
) checker_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .evt_valid (evt_valid),
    .evt_addr  (evt_addr),
    .evt_fail  (evt_fail),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_err   (cmd_err),
    .out_valid (out_valid),
    .out_last  (out_last),
    .live_vec  (live_vec)
);

// File: tb/pktvault_tb_top.sv
module pktvault_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int NUM_SLOTS  = 16;
    localparam int SLOT_WORDS = 64;
    localparam int SLOT_AW    = $clog2(NUM_SLOTS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_last = 1'b0;
    logic in_keep = 1'b0;
    logic evt_valid;
    logic [SLOT_AW-1:0] evt_addr;
    logic evt_fail;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [SLOT_AW-1:0] cmd_addr = '0;
    logic cmd_ready;
    logic cmd_err;
    logic out_valid;
    logic [DATA_W-1:0] out_data;
    logic out_last;

    int n_checks = 0;
    int n_fails  = 0;

    bit model_used [NUM_SLOTS];
    int model_len  [NUM_SLOTS];
    int model_tag  [NUM_SLOTS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pktvault #(
        .DATA_W     (DATA_W),
        .NUM_SLOTS  (NUM_SLOTS),
        .SLOT_WORDS (SLOT_WORDS)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_keep   (in_keep),
        .evt_valid (evt_valid),
        .evt_addr  (evt_addr),
        .evt_fail  (evt_fail),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_ready (cmd_ready),
        .cmd_err   (cmd_err),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    function automatic logic [DATA_W-1:0] mkword(int tag, int i);
        return {tag[15:0], i[15:0]};
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < NUM_SLOTS; i++) if (!model_used[i]) return i;
        return -1;
    endfunction

    // drive one packet, return the event seen after its last word
    task automatic send_pkt(int len, bit keep, int tag,
                            output bit ev, output int addr, output bit fail);
        bit stray = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (evt_valid) stray = 1;
            in_valid = 1'b1;
            in_data  = mkword(tag, i);
            in_last  = (i == len - 1);
            in_keep  = keep;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        ev   = evt_valid;
        addr = int'(evt_addr);
        fail = evt_fail;
        chk(!stray, "R2", "event before last word", int'(stray), 0);
    endtask

    // store expected to succeed in the lowest free slot
    task automatic store_ok(int len, int tag, string req);
        bit ev, fail;
        int addr;
        int exp_slot = lowest_free();
        send_pkt(len, 1'b1, tag, ev, addr, fail);
        chk(ev && !fail, req, "store event ok", int'(ev && !fail), 1);
        chk(addr == exp_slot, req, "store slot", addr, exp_slot);
        chk(!model_used[addr], "R3", "slot was live", int'(model_used[addr]), 0);
        model_used[addr] = 1;
        model_len[addr]  = len;
        model_tag[addr]  = tag;
    endtask

    // issue a command, collect any stream
    task automatic do_cmd(logic [1:0] op, int slot, output bit err,
                          output int nwords, output bit data_ok, output bit first_ok);
        nwords   = 0;
        data_ok  = 1;
        first_ok = 1;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = SLOT_AW'(slot);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
        err = cmd_err;
        if (out_valid) first_ok = 0;
        if (op[0] && !err) begin
            for (int c = 0; c < SLOT_WORDS + 8; c++) begin
                @(negedge clk);
                if (c == 0 && !out_valid) first_ok = 0;
                if (out_valid) begin
                    if (out_data !== mkword(model_tag[slot], nwords)) data_ok = 0;
                    if (out_last !== (nwords == model_len[slot] - 1)) data_ok = 0;
                    nwords++;
                    if (out_last) break;
                end
            end
        end
    endtask

    task automatic read_check(logic [1:0] op, int slot, string req);
        bit err, ok, fst;
        int n;
        do_cmd(op, slot, err, n, ok, fst);
        chk(!err, req, "read error flag", int'(err), 0);
        chk(n == model_len[slot], req, "read word count", n, model_len[slot]);
        chk(ok, req, "read data and last", int'(ok), 1);
        chk(fst, "R5", "first word timing", int'(fst), 1);
    endtask

    task automatic expect_err(logic [1:0] op, int slot, string req);
        bit err, ok, fst;
        int n;
        do_cmd(op, slot, err, n, ok, fst);
        chk(err, req, "error on dead slot", int'(err), 1);
        chk(n == 0, req, "no output words", n, 0);
    endtask

    task automatic t_reset();
        chk(!evt_valid, "R11", "evt_valid at reset", int'(evt_valid), 0);
        chk(!out_valid, "R11", "out_valid at reset", int'(out_valid), 0);
        chk(!cmd_err,   "R11", "cmd_err at reset", int'(cmd_err), 0);
        chk(cmd_ready,  "R11", "cmd_ready at reset", int'(cmd_ready), 1);
    endtask

    task automatic t_skip();
        bit ev, fail;
        int addr;
        send_pkt(4, 1'b0, 9, ev, addr, fail);
        chk(!ev, "R1", "event for unkept packet", int'(ev), 0);
        expect_err(2'b01, 0, "R1");
    endtask

    task automatic t_store_read();
        store_ok(1, 1, "R2");
        store_ok(5, 2, "R2");
        store_ok(SLOT_WORDS, 3, "R9");
        read_check(2'b01, 0, "R5");
        read_check(2'b01, 1, "R5");
        read_check(2'b01, 2, "R5");
    endtask

    task automatic t_reread();
        read_check(2'b01, 1, "R6");
        read_check(2'b01, 1, "R6");
    endtask

    task automatic t_free();
        bit err, ok, fst;
        int n;
        do_cmd(2'b10, 1, err, n, ok, fst);
        chk(!err, "R7", "free error flag", int'(err), 0);
        model_used[1] = 0;
        expect_err(2'b01, 1, "R7");
        store_ok(3, 4, "R7");
    endtask

    task automatic t_read_free();
        read_check(2'b11, 0, "R8");
        model_used[0] = 0;
        expect_err(2'b01, 0, "R8");
    endtask

    task automatic t_bad_cmd();
        bit err, ok, fst;
        int n;
        do_cmd(2'b00, 2, err, n, ok, fst);
        chk(!err, "R10", "no-op error flag", int'(err), 0);
        chk(n == 0, "R10", "no-op output", n, 0);
        expect_err(2'b10, 9, "R10");
        expect_err(2'b11, 12, "R10");
        read_check(2'b01, 2, "R10");
        store_ok(2, 5, "R10");
    endtask

    task automatic t_full();
        bit ev, fail;
        int addr;
        for (int s = 3; s < NUM_SLOTS; s++) store_ok(2, 16 + s, "R2");
        send_pkt(3, 1'b1, 40, ev, addr, fail);
        chk(ev && fail, "R4", "full pool refuses", int'(ev && fail), 1);
        chk(addr == 0, "R4", "refused handle", addr, 0);
        read_check(2'b01, NUM_SLOTS - 1, "R3");
        read_check(2'b01, 2, "R3");
    endtask

    task automatic t_oversize();
        bit ev, fail, err, ok, fst;
        int addr, n;
        do_cmd(2'b10, 7, err, n, ok, fst);
        chk(!err, "R7", "free slot 7", int'(err), 0);
        model_used[7] = 0;
        send_pkt(SLOT_WORDS + 1, 1'b1, 50, ev, addr, fail);
        chk(ev && fail, "R9", "oversize refused", int'(ev && fail), 1);
        store_ok(2, 51, "R9");
        chk(model_used[7] && model_tag[7] == 51, "R9", "slot returned", model_tag[7], 51);
        read_check(2'b01, 7, "R9");
        read_check(2'b01, 6, "R9");
        read_check(2'b01, 8, "R9");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    initial begin
        repeat (1000 * SLOT_WORDS) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            model_used[i] = 0;
            model_len[i]  = 0;
            model_tag[i]  = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_skip();
        t_store_read();
        t_reread();
        t_free();
        t_read_free();
        t_bad_cmd();
        t_full();
        t_oversize();
        summary();
        $finish;
    end

endmodule